// File: doc/BRIEF.md
# Banked Instruction Fetch Address Mapper

This block turns a word-addressed program counter into a physical fetch target. The PC is converted to a byte address by appending two zero bits. One bit of that byte address chooses one of two 16-bit bank map registers. The chosen map then sends the fetch to one of two places: internal instruction memory, or a numbered segment of unified memory.

For each fetch request the block returns three things, all registered: a target select, a byte offset and a fault flag. A valid strobe marks them one cycle after the request. The fault flag rises when a unified segment is chosen but that segment is not marked as present in the populated-segment input vector.

Software reads and writes both map registers through a small register port. The port has a write strobe, a register select and a write data word. A combinational read-back path returns the selected register.

Top module: `ifetch_map`

## Requirements
- R1: After reset both map registers read back 0x1000. `ack_vld` is 0.
- R2: The fetch byte address is the PC shifted left by two, truncated to `BADDR_W` (default 18) bits.
- R3: Byte-address bit 17 (PC bit 15) selects the bank. When it is 1, map register 1 is used. When it is 0, map register 0 is used.
- R4: When bit 12 of the selected map is 1, `tgt_imem` is 1 and `tgt_seg` is 0. The fault flag is 0.
- R5: When bit 12 of the selected map is 0, `tgt_imem` is 0 and `tgt_seg` equals map bits [7:0].
- R6: The fault flag is 1 exactly when the selected map has bit 12 clear and bit `tgt_seg` of `seg_present` is 0.
- R7: `ack_vld` is 1 in the cycle after a cycle with `req_vld` high, and 0 otherwise. Outputs hold their values while no request is made.
- R8: A write with `cfg_we` high loads `cfg_wdata` into the map register chosen by `cfg_sel` (0 or 1). The other register is unchanged. Read-back of the written value appears after the clock edge.
- R9: A map write and a fetch request in the same cycle: the fetch uses the map value from before the write.
- R10: `offset` equals the byte address for both target kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Fetch request strobe |
| req_pc | input | 16 | Word-addressed program counter |
| seg_present | input | 256 | One bit per unified segment, 1 = populated |
| cfg_we | input | 1 | Map register write strobe |
| cfg_sel | input | 1 | Map register select (0/1) |
| cfg_wdata | input | 16 | Map register write data |
| cfg_rdata | output | 16 | Read-back of selected map register |
| ack_vld | output | 1 | Result valid, one cycle after request |
| tgt_imem | output | 1 | 1 = internal instruction memory target |
| tgt_seg | output | 8 | Unified segment number |
| offset | output | 18 | Byte offset within target |
| fetch_fault | output | 1 | Unified segment not populated |

## Verification
The bench targets PC values on both sides of the bank-select boundary (0x7FFF and 0x8000). A mapper that used the wrong address bit would route these to the wrong map register. It also drives PCs with the top bits set, where a wrong shift or missing truncation would corrupt the offset. Segment numbers 0 and 255 are checked against a sparse population vector, which catches an off-by-one or reversed fault lookup. The last directed case is a map write landing in the same cycle as a fetch. A design that forwarded the new map value would report the wrong target for that fetch.

// File: rtl/ifetch_map_pkg.sv
// Package: shared widths, constants and result type for the fetch mapper.
package ifetch_map_pkg;
    localparam int MAP_W      = 16;
    localparam int IMEM_BIT   = 12;
    localparam int SEG_W      = 8;
    localparam logic [MAP_W-1:0] MAP_RST = 16'h1000;

    typedef struct packed {
        logic             imem;
        logic [SEG_W-1:0] seg;
        logic             fault;
    } route_t;
endpackage

// File: rtl/ifetch_map_regs.sv
// Two bank map registers with write port and combinational read-back.
// Assumes cfg_sel is a single bit; both registers reset to MAP_RST.
module ifetch_map_regs
    import ifetch_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [MAP_W-1:0] cfg_wdata,
    output logic [MAP_W-1:0] map0,
    output logic [MAP_W-1:0] map1,
    output logic [MAP_W-1:0] cfg_rdata
);
    logic [MAP_W-1:0] bank_q [2];

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_bank
            // Load bank gi when selected by a write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[gi] <= MAP_RST;
                else if (cfg_we && (cfg_sel == gi[0]))
                    bank_q[gi] <= cfg_wdata;
            end
        end
    endgenerate

    // Expose registers and read mux.
    always_comb begin
        map0      = bank_q[0];
        map1      = bank_q[1];
        cfg_rdata = cfg_sel ? bank_q[1] : bank_q[0];
    end
endmodule

// File: rtl/ifetch_map_route.sv
// Combinational route decode: picks bank by address bit, decides target and fault.
// Assumes SEG_CNT <= 2**SEG_W.
module ifetch_map_route
    import ifetch_map_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int BADDR_W = 18,
    parameter int SEG_CNT = 256
) (
    input  logic [PC_W-1:0]    pc,
    input  logic [MAP_W-1:0]   map0,
    input  logic [MAP_W-1:0]   map1,
    input  logic [SEG_CNT-1:0] seg_present,
    output logic [BADDR_W-1:0] baddr,
    output route_t             route
);
    localparam int BANK_BIT = 17;
    localparam int WIDE_W   = PC_W + 2;

    logic [WIDE_W-1:0] wide;
    logic [MAP_W-1:0]  sel_map;

    // Form byte address, choose bank, decode target.
    always_comb begin
        wide        = {pc, 2'b00};
        baddr       = wide[BADDR_W-1:0];
        sel_map     = wide[BANK_BIT] ? map1 : map0;
        route.imem  = sel_map[IMEM_BIT];
        route.seg   = route.imem ? '0 : sel_map[SEG_W-1:0];
        route.fault = !route.imem && !seg_present[route.seg];
    end
endmodule

// File: rtl/ifetch_map.sv
// Top: registers the decoded fetch route one cycle after each request.
// Assumes synchronous active-low reset; outputs hold between requests.
module ifetch_map
    import ifetch_map_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int BADDR_W = 18,
    parameter int SEG_CNT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld,
    input  logic [PC_W-1:0]    req_pc,
    input  logic [SEG_CNT-1:0] seg_present,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [MAP_W-1:0]   cfg_wdata,
    output logic [MAP_W-1:0]   cfg_rdata,
    output logic               ack_vld,
    output logic               tgt_imem,
    output logic [SEG_W-1:0]   tgt_seg,
    output logic [BADDR_W-1:0] offset,
    output logic               fetch_fault
);
    logic [MAP_W-1:0]   map0, map1;
    logic [BADDR_W-1:0] baddr;
    route_t             route;

    ifetch_map_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .map0(map0), .map1(map1), .cfg_rdata(cfg_rdata)
    );

    ifetch_map_route #(.PC_W(PC_W), .BADDR_W(BADDR_W), .SEG_CNT(SEG_CNT)) u_route (
        .pc(req_pc), .map0(map0), .map1(map1), .seg_present(seg_present),
        .baddr(baddr), .route(route)
    );

    // Valid strobe follows request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_vld <= 1'b0;
        else        ack_vld <= req_vld;
    end

    // Capture route on request; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_imem    <= 1'b0;
            tgt_seg     <= '0;
            offset      <= '0;
            fetch_fault <= 1'b0;
        end else if (req_vld) begin
            tgt_imem    <= route.imem;
            tgt_seg     <= route.seg;
            offset      <= baddr;
            fetch_fault <= route.fault;
        end
    end
endmodule

// File: rtl/ifetch_map_chk.sv
// Checker: temporal properties on the mapper ports, bound to every instance.
module ifetch_map_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld,
    input logic [15:0] req_pc,
    input logic        ack_vld,
    input logic        tgt_imem,
    input logic [7:0]  tgt_seg,
    input logic [17:0] offset,
    input logic        fetch_fault
);
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> ack_vld); // R7
    AST_ACK_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !ack_vld); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> $stable(offset) && $stable(tgt_seg) && $stable(tgt_imem)); // R7
    AST_IMEM_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld && tgt_imem |-> !fetch_fault && tgt_seg == 8'd0); // R4
    AST_OFFSET_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> offset == {$past(req_pc[15:0]), 2'b00}); // R2
endmodule

bind ifetch_map ifetch_map_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_pc(req_pc),
    .ack_vld(ack_vld), .tgt_imem(tgt_imem), .tgt_seg(tgt_seg),
    .offset(offset), .fetch_fault(fetch_fault)
);

// File: tb/ifetch_map_bench.sv
module ifetch_map_bench;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         req_vld = 0;
    logic [15:0]  req_pc = 0;
    logic [255:0] seg_present = 0;
    logic         cfg_we = 0, cfg_sel = 0;
    logic [15:0]  cfg_wdata = 0;
    logic [15:0]  cfg_rdata;
    logic         ack_vld, tgt_imem, fetch_fault;
    logic [7:0]   tgt_seg;
    logic [17:0]  offset;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m0 = 16'h1000, m1 = 16'h1000;

    always #2 clk = ~clk;

    ifetch_map u_ifetch_map (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pick(input logic [15:0] pc);
        return pc[15] ? m1 : m0;
    endfunction

    // Issue one fetch and check results after the edge.
    task automatic fetch(input logic [15:0] pc);
        logic [15:0] m;
        logic        im;
        logic [7:0]  sg;
        m  = pick(pc);
        im = m[12];
        sg = im ? 8'd0 : m[7:0];
        req_pc = pc; req_vld = 1;
        @(posedge clk); #1;
        req_vld = 0;
        chk("R7 ack", {31'd0, ack_vld}, 32'd1);
        chk("R2/R10 offset", {14'd0, offset}, {14'd0, pc, 2'b00});
        chk("R3/R4 imem", {31'd0, tgt_imem}, {31'd0, im});
        chk("R5 seg", {24'd0, tgt_seg}, {24'd0, sg});
        chk("R6 fault", {31'd0, fetch_fault}, {31'd0, !im && !seg_present[sg]});
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
        if (sel) m1 = d; else m0 = d;
    endtask

    initial begin
        #40000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        seg_present = 0;
        seg_present[0] = 1; seg_present[5] = 1; seg_present[200] = 1;
        repeat (2) @(posedge clk); #1;
        rst_n = 1;
        cfg_sel = 0; #0.5;
        chk("R1 map0 reset", {16'd0, cfg_rdata}, 32'h1000);
        cfg_sel = 1; #0.5;
        chk("R1 map1 reset", {16'd0, cfg_rdata}, 32'h1000);
        chk("R1 ack reset", {31'd0, ack_vld}, 0);
        fetch(16'h0123);
        fetch(16'hFFFF);
        // R8: write map0 to segment 5, map1 unchanged
        wr(0, 16'h0005);
        cfg_sel = 0; #0.5;
        chk("R8 map0", {16'd0, cfg_rdata}, 32'h0005);
        cfg_sel = 1; #0.5;
        chk("R8 map1 untouched", {16'd0, cfg_rdata}, 32'h1000);
        // R3 boundary
        fetch(16'h7FFF);
        fetch(16'h8000);
        wr(1, 16'h00FF); // segment 255 absent
        fetch(16'h8004);
        wr(0, 16'h0000);
        fetch(16'h0000);
        wr(0, 16'h0007); // absent
        fetch(16'h0010);
        // R7 hold while idle
        begin
            logic [17:0] o;
            o = offset;
            req_pc = 16'h1234;
            @(posedge clk); #1;
            chk("R7 idle ack", {31'd0, ack_vld}, 0);
            chk("R7 hold", {14'd0, offset}, {14'd0, o});
        end
        // R9: write same cycle as fetch uses old map
        begin
            logic [15:0] old;
            old = m0;
            cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'h10C8;
            req_vld = 1; req_pc = 16'h0040;
            @(posedge clk); #1;
            cfg_we = 0; req_vld = 0;
            chk("R9 old seg", {24'd0, tgt_seg}, {24'd0, old[7:0]});
            chk("R9 old imem", {31'd0, tgt_imem}, {31'd0, old[12]});
            m0 = 16'h10C8;
        end
        // Random mix
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 3) == 0)
                wr(1'($urandom_range(0, 1)), 16'($urandom));
            if ($urandom_range(0, 7) == 0)
                seg_present = {$urandom, $urandom, $urandom, $urandom,
                               $urandom, $urandom, $urandom, $urandom};
            fetch(16'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule